// File: doc/BRIEF.md
# Two-Thread Decode Slot Throttle with Dormancy Control

This block sits in front of the decode stage of a core that runs two hardware threads at the same time. It decides, cycle by cycle, which of the two threads may decode. Each thread has a 3-bit priority that software can write. The block turns the two priorities into a repeating 16-cycle slot pattern. When the levels differ, the thread with the lower level gets a share of the slots that halves with each step of difference. When the levels are equal, the two threads alternate.

Software can also put one thread to sleep. While a thread is dormant, every slot goes to the remaining thread. The dormant thread wakes when an external interrupt, a decrementer interrupt or a wake instruction from the running thread arrives.

Each thread also supplies an idle hint. A slot owned by a thread that is idle in that cycle goes to the other thread when that thread can use it. All pins are plain control and status lines. There is no data stream and no back-pressure.

Top module: `smt_decode_throttle`

## Requirements
- R1: After reset both priorities hold 4, no thread is dormant and the slot window starts at position 0. In the first cycle thread 0 holds the decode slot.
- R2: Setting bit i of `prio_wr_en` loads `prio_wr_val` into the priority of thread i. The new value governs the slot choice from the next cycle on. Both bits may be set in the same cycle.
- R3: When both threads are eligible (priority non-zero and not dormant) and their levels are equal, they alternate. Thread 0 takes the even window positions and thread 1 takes the odd ones.
- R4: When both are eligible and the levels differ by d, the lower-level thread owns window positions 0 to S-1, where S is 16>>d for d below 4 and 1 otherwise. The higher-level thread owns the remaining positions of the 16-cycle window. The window position advances by one every cycle.
- R5: A thread at priority 0 never gets a slot, and the other eligible thread takes every slot. If neither thread is eligible, both decode enables stay low.
- R6: If the owner of the slot is idle in that cycle, the slot goes to the other thread when that thread is eligible and not idle. Otherwise the owner keeps the slot.
- R7: At most one decode enable is high in any cycle.
- R8: A sleep request makes the selected thread (`sleep_thr`, 0 or 1) dormant from the next cycle on, but only when no thread is dormant yet. A dormant thread gets no slot, and the other thread takes every slot.
- R9: Any of `ext_irq`, `dec_irq` or `wake_insn` clears dormancy from the next cycle on.
- R10: A wake event in the same cycle as a sleep request wins, and the thread stays awake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_wr_en | input | 2 | Per-thread priority write strobe |
| prio_wr_val | input | 3 | Priority value to write |
| sleep_req | input | 1 | Software sleep command |
| sleep_thr | input | 1 | Thread to put to sleep |
| ext_irq | input | 1 | External interrupt wake event |
| dec_irq | input | 1 | Decrementer interrupt wake event |
| wake_insn | input | 1 | Wake instruction from the running thread |
| idle_hint | input | 2 | Per-thread idle hint for the current cycle |
| decode_en | output | 2 | Per-thread decode enable |
| dormant | output | 2 | Per-thread dormant flag |

## Verification
Equal levels at 4 and at 7 show that alternation does not depend on the absolute level. Differences of 1, 2, 4 and 6 cover the halving rule, the one-slot floor and the case where the lower thread is thread 1 rather than thread 0. Level 0 on one thread and then on both separates stopping a thread from leaving the decoder empty.

Idle hints on each thread and on both show when a slot is handed over and when it is kept. Sleep, each of the three wake events, and sleep together with a wake show the ordering of the dormancy state.

// File: rtl/smt_throttle_pkg.sv
package smt_throttle_pkg;
  localparam int NUM_THR = 2;

  typedef struct packed {
    logic vld;
    logic tid;
  } slot_grant_t;
endpackage

// File: rtl/smt_prio_regs.sv
module smt_prio_regs #(
  parameter int PRIO_W   = 3,
  parameter int RST_PRIO = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             wr_en,
  input  logic [PRIO_W-1:0]      wr_val,
  output logic [1:0][PRIO_W-1:0] prio
);
  localparam logic [PRIO_W-1:0] RST_VAL = PRIO_W'(RST_PRIO);

  for (genvar i = 0; i < smt_throttle_pkg::NUM_THR; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n)        prio[i] <= RST_VAL;
      else if (wr_en[i]) prio[i] <= wr_val;
    end

    // R2: a write lands in the addressed register one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> prio[i] == $past(wr_val));
  end
endmodule

// File: rtl/smt_dormancy.sv
module smt_dormancy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       sleep_thr,
  input  logic       ext_irq,
  input  logic       dec_irq,
  input  logic       wake_insn,
  output logic [1:0] dormant
);
  logic wake_any;
  assign wake_any = ext_irq | dec_irq | wake_insn;

  always_ff @(posedge clk) begin
    if (!rst_n)                           dormant <= '0;
    else if (wake_any)                    dormant <= '0;
    else if (sleep_req && dormant == '0)  dormant[sleep_thr] <= 1'b1;
  end

  // R8: never both threads asleep
  a_r8_one_sleeper: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dormant));
  // R8: an accepted sleep request puts the named thread to sleep
  a_r8_sleep_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !wake_any && dormant == 2'b00) |=> dormant[$past(sleep_thr)]);
  // R9: any wake source clears dormancy
  a_r9_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> dormant == 2'b00);
  // R10: wake beats a simultaneous sleep request
  a_r10_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && wake_any) |=> dormant == 2'b00);
endmodule

// File: rtl/smt_slot_sched.sv
module smt_slot_sched
  import smt_throttle_pkg::*;
#(
  parameter int PRIO_W   = 3,
  parameter int WIN_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0][PRIO_W-1:0] prio,
  input  logic [1:0]             dormant,
  output logic [1:0]             elig,
  output slot_grant_t            grant
);
  localparam int SHARE_W = WIN_BITS + 1;
  localparam logic [SHARE_W-1:0] WINDOW = SHARE_W'(1) << WIN_BITS;

  logic [WIN_BITS-1:0] win_pos;
  logic [PRIO_W-1:0]   diff;
  logic                low_thr;
  logic [SHARE_W-1:0]  share;
  logic                prio_eq;
  logic                past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_pos <= '0;
      past_ok <= 1'b0;
    end else begin
      win_pos <= win_pos + 1'b1;
      past_ok <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_THR; i++) begin : g_elig
    assign elig[i] = (prio[i] != '0) && !dormant[i];
  end

  assign prio_eq = (prio[0] == prio[1]);
  assign low_thr = (prio[1] < prio[0]);
  assign diff    = low_thr ? (prio[0] - prio[1]) : (prio[1] - prio[0]);

  always_comb begin
    if (int'(diff) >= WIN_BITS) share = SHARE_W'(1);
    else                        share = WINDOW >> diff;
  end

  always_comb begin
    grant.vld = (elig != 2'b00);
    unique case (elig)
      2'b01:   grant.tid = 1'b0;
      2'b10:   grant.tid = 1'b1;
      default: begin
        if (prio_eq)                   grant.tid = win_pos[0];
        else if ({1'b0, win_pos} < share) grant.tid = low_thr;
        else                           grant.tid = ~low_thr;
      end
    endcase
  end

  // R3: equal levels on two eligible threads alternate every cycle
  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && elig == 2'b11 && prio_eq && $past(elig) == 2'b11 &&
     $past(prio[0] == prio[1])) |-> grant.tid != $past(grant.tid));
endmodule

// File: rtl/smt_slot_arb.sv
module smt_slot_arb
  import smt_throttle_pkg::*;
(
  input  slot_grant_t grant,
  input  logic [1:0]  elig,
  input  logic [1:0]  idle_hint,
  output logic [1:0]  decode_en
);
  logic pick;
  logic alt;

  assign alt = ~grant.tid;

  always_comb begin
    pick = grant.tid;
    if (idle_hint[grant.tid] && elig[alt] && !idle_hint[alt]) pick = alt;
    decode_en = 2'b00;
    if (grant.vld) decode_en[pick] = 1'b1;
  end
endmodule

// File: rtl/smt_decode_throttle.sv
module smt_decode_throttle
  import smt_throttle_pkg::*;
#(
  parameter int PRIO_W   = 3,
  parameter int WIN_BITS = 4,
  parameter int RST_PRIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        prio_wr_en,
  input  logic [PRIO_W-1:0] prio_wr_val,
  input  logic              sleep_req,
  input  logic              sleep_thr,
  input  logic              ext_irq,
  input  logic              dec_irq,
  input  logic              wake_insn,
  input  logic [1:0]        idle_hint,
  output logic [1:0]        decode_en,
  output logic [1:0]        dormant
);
  logic [1:0][PRIO_W-1:0] prio_q;
  logic [1:0]             elig;
  slot_grant_t            grant;

  smt_prio_regs #(.PRIO_W(PRIO_W), .RST_PRIO(RST_PRIO)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(prio_wr_en), .wr_val(prio_wr_val),
    .prio(prio_q));

  smt_dormancy u_dorm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_thr(sleep_thr),
    .ext_irq(ext_irq), .dec_irq(dec_irq), .wake_insn(wake_insn),
    .dormant(dormant));

  smt_slot_sched #(.PRIO_W(PRIO_W), .WIN_BITS(WIN_BITS)) u_sched (
    .clk(clk), .rst_n(rst_n), .prio(prio_q), .dormant(dormant),
    .elig(elig), .grant(grant));

  smt_slot_arb u_arb (
    .grant(grant), .elig(elig), .idle_hint(idle_hint), .decode_en(decode_en));

  // R7: at most one thread decodes per cycle
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(decode_en));

  for (genvar i = 0; i < NUM_THR; i++) begin : g_chk
    // R8: a sleeping thread never decodes
    a_r8_dormant_silent: assert property (@(posedge clk) disable iff (!rst_n)
      dormant[i] |-> !decode_en[i]);
    // R5: a stopped thread never decodes
    a_r5_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_q[i] == '0) |-> !decode_en[i]);
  end

  // R6: an idle owner hands its slot to a ready, eligible peer
  a_r6_idle_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (grant.vld && idle_hint[grant.tid] && elig[~grant.tid] &&
     !idle_hint[~grant.tid]) |-> decode_en[~grant.tid]);
endmodule

// File: tb/smt_decode_throttle_bench.sv
module smt_decode_throttle_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] prio_wr_en = '0;
  logic [2:0] prio_wr_val = '0;
  logic       sleep_req = 1'b0;
  logic       sleep_thr = 1'b0;
  logic       ext_irq = 1'b0;
  logic       dec_irq = 1'b0;
  logic       wake_insn = 1'b0;
  logic [1:0] idle_hint = '0;
  logic [1:0] decode_en;
  logic [1:0] dormant;

  always #2.5 clk = ~clk;

  smt_decode_throttle u_smt_decode_throttle (
    .clk(clk), .rst_n(rst_n), .prio_wr_en(prio_wr_en), .prio_wr_val(prio_wr_val),
    .sleep_req(sleep_req), .sleep_thr(sleep_thr), .ext_irq(ext_irq),
    .dec_irq(dec_irq), .wake_insn(wake_insn), .idle_hint(idle_hint),
    .decode_en(decode_en), .dormant(dormant));

  typedef struct {
    logic [1:0] en;
    logic [1:0] dorm;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // reference model state
  int         m_prio0, m_prio1, m_cnt;
  logic [1:0] m_dorm;
  logic [1:0] p_wr_en;
  int         p_wr_val;
  logic       p_slp, p_thr, p_wake;

  function automatic logic [1:0] exp_en(int p0, int p1, logic [1:0] dm,
                                        int pos, logic [1:0] idl);
    logic [1:0] el;
    int owner, other, d, s, lo;
    el[0] = (p0 != 0) && !dm[0];
    el[1] = (p1 != 0) && !dm[1];
    if (el == 2'b00) return 2'b00;
    if (el == 2'b01) owner = 0;
    else if (el == 2'b10) owner = 1;
    else if (p0 == p1) owner = pos % 2;
    else begin
      lo = (p0 < p1) ? 0 : 1;
      d  = (p0 < p1) ? p1 - p0 : p0 - p1;
      s  = 16;
      for (int k = 0; k < d; k++) s = s / 2;
      if (s < 1) s = 1;
      owner = (pos < s) ? lo : 1 - lo;
    end
    other = 1 - owner;
    if (idl[owner] && el[other] && !idl[other]) owner = other;
    return (owner == 0) ? 2'b01 : 2'b10;
  endfunction

  task automatic push_exp(string tag);
    exp_t e;
    e.en   = exp_en(m_prio0, m_prio1, m_dorm, m_cnt, idle_hint);
    e.dorm = m_dorm;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // driver: advance model with last cycle's inputs, drive new ones, push expectation
  task automatic cyc(logic [1:0] we, int wv, logic slp, logic thr,
                     logic [2:0] wk, logic [1:0] idl, string tag);
    @(posedge clk); #1;
    if (p_wr_en[0]) m_prio0 = p_wr_val;
    if (p_wr_en[1]) m_prio1 = p_wr_val;
    if (p_wake) m_dorm = 2'b00;
    else if (p_slp && m_dorm == 2'b00) m_dorm[p_thr] = 1'b1;
    m_cnt = (m_cnt + 1) % 16;
    prio_wr_en  = we;
    prio_wr_val = 3'(wv);
    sleep_req   = slp;
    sleep_thr   = thr;
    ext_irq     = wk[2];
    dec_irq     = wk[1];
    wake_insn   = wk[0];
    idle_hint   = idl;
    p_wr_en = we; p_wr_val = wv; p_slp = slp; p_thr = thr; p_wake = |wk;
    push_exp(tag);
  endtask

  task automatic run(int n, logic [1:0] idl, string tag);
    for (int k = 0; k < n; k++) cyc(2'b00, 0, 1'b0, 1'b0, 3'b000, idl, tag);
  endtask

  task automatic wr(logic [1:0] we, int wv);
    cyc(we, wv, 1'b0, 1'b0, 3'b000, 2'b00, "R2");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (decode_en !== e.en) begin
          errors++;
          $display("FAIL %s decode_en actual=%b expected=%b", e.tag, decode_en, e.en);
        end
        checks++;
        if (dormant !== e.dorm) begin
          errors++;
          $display("FAIL %s dormant actual=%b expected=%b", e.tag, dormant, e.dorm);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_prio0 = 4; m_prio1 = 4; m_cnt = 0; m_dorm = 2'b00;
    p_wr_en = 2'b00; p_wr_val = 0; p_slp = 1'b0; p_thr = 1'b0; p_wake = 1'b0;
    push_exp("R1");
    run(3, 2'b00, "R3");
    // R3 at the top level
    wr(2'b11, 7);
    run(4, 2'b00, "R3");
    // R4: various differences
    wr(2'b01, 5);
    run(16, 2'b00, "R4");
    wr(2'b10, 4);
    run(16, 2'b00, "R4");
    wr(2'b01, 1);
    wr(2'b10, 7);
    run(16, 2'b00, "R4");
    wr(2'b01, 7);
    wr(2'b10, 3);
    run(16, 2'b00, "R4");
    // R5: stopped threads
    wr(2'b01, 0);
    run(4, 2'b00, "R5");
    wr(2'b10, 0);
    run(3, 2'b00, "R5");
    wr(2'b11, 4);
    // R6: idle handover
    run(4, 2'b01, "R6");
    run(4, 2'b10, "R6");
    run(2, 2'b11, "R6");
    wr(2'b01, 2);
    wr(2'b10, 6);
    run(6, 2'b10, "R6");
    wr(2'b11, 4);
    run(2, 2'b00, "R7");
    // R8: sleep
    cyc(2'b00, 0, 1'b1, 1'b1, 3'b000, 2'b00, "R8");
    run(4, 2'b00, "R8");
    run(2, 2'b01, "R8");
    cyc(2'b00, 0, 1'b1, 1'b0, 3'b000, 2'b00, "R8");
    run(3, 2'b00, "R8");
    // R9: each wake source
    cyc(2'b00, 0, 1'b0, 1'b0, 3'b100, 2'b00, "R9");
    run(2, 2'b00, "R9");
    cyc(2'b00, 0, 1'b1, 1'b0, 3'b000, 2'b00, "R8");
    run(2, 2'b00, "R8");
    cyc(2'b00, 0, 1'b0, 1'b0, 3'b010, 2'b00, "R9");
    run(2, 2'b00, "R9");
    cyc(2'b00, 0, 1'b1, 1'b1, 3'b000, 2'b00, "R8");
    run(1, 2'b00, "R8");
    cyc(2'b00, 0, 1'b0, 1'b0, 3'b001, 2'b00, "R9");
    run(2, 2'b00, "R9");
    // R10: wake together with sleep
    cyc(2'b00, 0, 1'b1, 1'b0, 3'b100, 2'b00, "R10");
    run(2, 2'b00, "R10");
    cyc(2'b00, 0, 1'b1, 1'b1, 3'b001, 2'b00, "R10");
    run(2, 2'b00, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule